// File: doc/BRIEF.md
# Descriptor-Fetching Memory Copy Channel

This block is one memory-to-memory copy channel. Software places a four-word descriptor in memory and stores its address in the channel. It then sets the run bit. The channel reads the descriptor over its own memory master port, then moves the requested number of 32-bit words from source to destination, one read followed by one write per word. Each address either steps by four bytes per word or stays fixed, as the descriptor selects.

When the last word has been written, the run bit drops by itself. If the descriptor asked for it, a completion flag rises and drives the interrupt output until software writes a one to clear it. The register window of the channel starts at `CHAN_ID * 0x100`. A shared summary word at `0xFE0` shows the flag at bit position `CHAN_ID`, so several channels can sit on one register bus.

Every memory access uses a request/grant handshake. Read data comes back later, qualified by a valid strobe.

Top module: `dma_channel`

## Requirements
- R1: After reset the control word (window offset 0x00), the descriptor pointer (offset 0x04) and the summary word (0xFE0) read zero, `irq` is low and `mem_req` is low.
- R2: Writing the control word with bit 0 set while idle starts a transfer. Bit 0 reads one while the transfer runs and returns to zero by itself after the last data word is written.
- R3: The descriptor pointer at offset 0x04 is a full 32-bit read/write register.
- R4: On start the channel reads the descriptor words at pointer+0, +4, +8 and +12, in that order. These are the options word, the source address, the destination address and the length in bytes. It then performs exactly length/4 word copies. A length below 4 performs no data access at all.
- R5: Options bit 8 set makes the source address advance by 4 after each word. Clear, every read uses the same source address.
- R6: Options bit 4 set makes the destination address advance by 4 after each word. Clear, every write goes to the same destination address.
- R7: At completion with options bit 0 set, control bit 2 and `irq` become one. With options bit 0 clear they stay zero.
- R8: Writing the control word with bit 2 set clears the completion flag. Writing it with bit 2 clear leaves the flag unchanged.
- R9: The summary word at 0xFE0 shows the completion flag at bit `CHAN_ID` and zero elsewhere. Writes to another channel's window do not start or change this channel.
- R10: Control writes while a transfer runs do not restart or stop it: bit 0 stays one and the word count is unchanged.
- R11: A memory request keeps its address and direction stable until granted. Read data is taken only on the `mem_rvalid` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | Register write when high, read when low |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from address) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_gnt | input | 1 | Memory accepts the current request |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| irq | output | 1 | Completion flag |

## Verification
The hardest condition to reach from the ports is a register write that lands while a copy is in flight, because an unstalled transfer finishes within a few dozen cycles. The bench's memory model withholds grants on a pseudo-random pattern, which stretches each copy. Control writes issued right after the start then arrive mid-transfer, and the bench counts the memory writes to show that the word count did not change. The descriptor fetch order and the fixed-address modes are checked by logging every accepted read address and comparing the whole memory image against a model built from the requirements.

// File: rtl/dma_ch_pkg.sv
package dma_ch_pkg;

    localparam int REG_AW     = 12;
    localparam int WORD_BYTES = 4;

    // register window offsets and shared summary address
    localparam logic [7:0]        OFS_CTRL     = 8'h00;
    localparam logic [7:0]        OFS_DESC_PTR = 8'h04;
    localparam logic [REG_AW-1:0] ADDR_SUMMARY = 12'hFE0;

    // control word bits
    localparam int CTRL_RUN_BIT  = 0;
    localparam int CTRL_FLAG_BIT = 2;

    // options word bits
    localparam int OPT_IRQ_BIT  = 0;
    localparam int OPT_DINC_BIT = 4;
    localparam int OPT_SINC_BIT = 8;

    // index of the length word inside the descriptor
    localparam logic [1:0] DESC_LAST_IDX = 2'd3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DESC_REQ,
        ST_DESC_WAIT,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_WR_REQ,
        ST_FINISH
    } eng_state_e;

    typedef struct packed {
        logic        irq_en;
        logic        dst_inc;
        logic        src_inc;
        logic [31:0] src;
        logic [31:0] dst;
    } xfer_cfg_t;

    function automatic logic [31:0] desc_word_addr(input logic [31:0] base, input logic [1:0] idx);
        return base + {28'd0, idx, 2'b00};
    endfunction

    function automatic logic [31:0] step_addr(input logic [31:0] addr, input logic inc);
        return inc ? addr + 32'(WORD_BYTES) : addr;
    endfunction

endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step
    import dma_ch_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step,
    input  logic          inc_en,
    output logic [AW-1:0] addr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
        end else if (load) begin
            addr <= load_val;
        end else if (step) begin
            addr <= step_addr(addr, inc_en);
        end
    end

endmodule

// File: rtl/dma_ch_regs.sv
module dma_ch_regs
    import dma_ch_pkg::*;
#(
    parameter int CHAN_ID = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_en,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              done,
    input  logic              done_irq,
    output logic              start,
    output logic [31:0]       desc_ptr,
    output logic              active,
    output logic              flag
);

    localparam logic [3:0] WIN_ID = 4'(CHAN_ID);

    logic in_window, ctrl_hit, ptr_hit, sum_hit, ctrl_wr, ptr_wr;

    always_comb begin
        in_window = (reg_addr[11:8] == WIN_ID);
        ctrl_hit  = in_window && (reg_addr[7:0] == OFS_CTRL);
        ptr_hit   = in_window && (reg_addr[7:0] == OFS_DESC_PTR);
        sum_hit   = (reg_addr == ADDR_SUMMARY);
        ctrl_wr   = reg_en && reg_we && ctrl_hit;
        ptr_wr    = reg_en && reg_we && ptr_hit;
        // a start request is only honoured while idle
        start     = ctrl_wr && reg_wdata[CTRL_RUN_BIT] && !active;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            flag     <= 1'b0;
            desc_ptr <= '0;
        end else begin
            if (start) begin
                active <= 1'b1;
            end else if (done) begin
                active <= 1'b0;
            end

            // a completion in the same cycle as a clear wins
            if (done && done_irq) begin
                flag <= 1'b1;
            end else if (ctrl_wr && reg_wdata[CTRL_FLAG_BIT]) begin
                flag <= 1'b0;
            end

            if (ptr_wr) begin
                desc_ptr <= reg_wdata;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (ctrl_hit) begin
            reg_rdata[CTRL_RUN_BIT]  = active;
            reg_rdata[CTRL_FLAG_BIT] = flag;
        end else if (ptr_hit) begin
            reg_rdata = desc_ptr;
        end else if (sum_hit) begin
            reg_rdata[CHAN_ID] = flag;
        end
    end

endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
    import dma_ch_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [31:0] desc_ptr,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_gnt,
    input  logic        mem_rvalid,
    input  logic [31:0] mem_rdata,
    output logic        done,
    output logic        done_irq
);

    eng_state_e  state;
    xfer_cfg_t   cfg;
    logic [31:0] desc_base;
    logic [1:0]  idx;
    logic [29:0] remaining;
    logic [31:0] data_q;
    logic [31:0] src_addr, dst_addr;
    logic        ptr_load, src_step, dst_step;

    assign ptr_load = (state == ST_DESC_WAIT) && mem_rvalid && (idx == DESC_LAST_IDX);
    assign src_step = (state == ST_RD_REQ) && mem_gnt;
    assign dst_step = (state == ST_WR_REQ) && mem_gnt;

    dma_addr_step #(.AW(32)) u_src_ptr (
        .clk     (clk),
        .rst     (rst),
        .load    (ptr_load),
        .load_val(cfg.src),
        .step    (src_step),
        .inc_en  (cfg.src_inc),
        .addr    (src_addr)
    );

    dma_addr_step #(.AW(32)) u_dst_ptr (
        .clk     (clk),
        .rst     (rst),
        .load    (ptr_load),
        .load_val(cfg.dst),
        .step    (dst_step),
        .inc_en  (cfg.dst_inc),
        .addr    (dst_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cfg       <= '0;
            desc_base <= '0;
            idx       <= '0;
            remaining <= '0;
            data_q    <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        desc_base <= desc_ptr;
                        idx       <= '0;
                        state     <= ST_DESC_REQ;
                    end
                end
                ST_DESC_REQ: begin
                    if (mem_gnt) state <= ST_DESC_WAIT;
                end
                ST_DESC_WAIT: begin
                    if (mem_rvalid) begin
                        case (idx)
                            2'd0: begin
                                cfg.irq_en  <= mem_rdata[OPT_IRQ_BIT];
                                cfg.dst_inc <= mem_rdata[OPT_DINC_BIT];
                                cfg.src_inc <= mem_rdata[OPT_SINC_BIT];
                            end
                            2'd1:    cfg.src   <= mem_rdata;
                            2'd2:    cfg.dst   <= mem_rdata;
                            default: remaining <= mem_rdata[31:2];
                        endcase
                        if (idx == DESC_LAST_IDX) begin
                            state <= (mem_rdata[31:2] == '0) ? ST_FINISH : ST_RD_REQ;
                        end else begin
                            idx   <= idx + 2'd1;
                            state <= ST_DESC_REQ;
                        end
                    end
                end
                ST_RD_REQ: begin
                    if (mem_gnt) state <= ST_RD_WAIT;
                end
                ST_RD_WAIT: begin
                    if (mem_rvalid) begin
                        data_q <= mem_rdata;
                        state  <= ST_WR_REQ;
                    end
                end
                ST_WR_REQ: begin
                    if (mem_gnt) begin
                        remaining <= remaining - 30'd1;
                        state     <= (remaining == 30'd1) ? ST_FINISH : ST_RD_REQ;
                    end
                end
                ST_FINISH: state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req  = 1'b0;
        mem_we   = 1'b0;
        mem_addr = '0;
        case (state)
            ST_DESC_REQ: begin
                mem_req  = 1'b1;
                mem_addr = desc_word_addr(desc_base, idx);
            end
            ST_RD_REQ: begin
                mem_req  = 1'b1;
                mem_addr = src_addr;
            end
            ST_WR_REQ: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = dst_addr;
            end
            default: ;
        endcase
    end

    assign mem_wdata = data_q;
    assign done      = (state == ST_FINISH);
    assign done_irq  = cfg.irq_en;

endmodule

// File: rtl/dma_channel.sv
module dma_channel
    import dma_ch_pkg::*;
#(
    parameter int CHAN_ID = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_en,
    input  logic        reg_we,
    input  logic [11:0] reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_gnt,
    input  logic        mem_rvalid,
    input  logic [31:0] mem_rdata,
    output logic        irq
);

    logic        eng_start, eng_done, eng_done_irq, ch_active;
    logic [31:0] desc_ptr;

    dma_ch_regs #(.CHAN_ID(CHAN_ID)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .reg_en   (reg_en),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .done     (eng_done),
        .done_irq (eng_done_irq),
        .start    (eng_start),
        .desc_ptr (desc_ptr),
        .active   (ch_active),
        .flag     (irq)
    );

    dma_xfer_engine u_engine (
        .clk       (clk),
        .rst       (rst),
        .start     (eng_start),
        .desc_ptr  (desc_ptr),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_gnt   (mem_gnt),
        .mem_rvalid(mem_rvalid),
        .mem_rdata (mem_rdata),
        .done      (eng_done),
        .done_irq  (eng_done_irq)
    );

endmodule

// File: rtl/dma_channel_chk.sv
module dma_channel_chk #(
    parameter int CHAN_ID = 2
) (
    input logic        clk,
    input logic        rst,
    input logic        reg_en,
    input logic        reg_we,
    input logic [11:0] reg_addr,
    input logic [31:0] reg_wdata,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic        mem_gnt,
    input logic        irq,
    input logic        active,
    input logic        done
);

    logic ctrl_clear;
    assign ctrl_clear = reg_en && reg_we && (reg_addr == {4'(CHAN_ID), 8'h00}) && reg_wdata[2];

    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> (!irq && !active && !mem_req));

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R2
    req_needs_active_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> active);

    // R10
    run_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (active && !done) |=> active);

    // R7
    flag_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(done));

    // R8
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_clear && !done) |=> !irq);

endmodule

bind dma_channel dma_channel_chk #(.CHAN_ID(CHAN_ID)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .reg_en   (reg_en),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_gnt  (mem_gnt),
    .irq      (irq),
    .active   (ch_active),
    .done     (eng_done)
);

// File: tb/dma_channel_tb.sv
module dma_channel_tb;

    localparam int CLK_PERIOD = 10;
    localparam int CHAN_ID    = 2;
    localparam int MEM_WORDS  = 256;
    localparam logic [31:0] MARK     = 32'h1234_5678;
    localparam logic [31:0] DESC_AT  = 32'h0000_0100;
    localparam logic [11:0] CTRL_A   = {4'(CHAN_ID), 8'h00};
    localparam logic [11:0] PTR_A    = {4'(CHAN_ID), 8'h04};
    localparam logic [11:0] SUM_A    = 12'hFE0;
    localparam int NVEC = 6;

    // each row: options, source, destination, length in bytes
    localparam logic [31:0] VEC [NVEC][4] = '{
        '{32'h111, 32'h020, 32'h040, 32'd32},
        '{32'h110, 32'h080, 32'h0C0, 32'd16},
        '{32'h101, 32'h020, 32'h200, 32'd12},
        '{32'h011, 32'h024, 32'h300, 32'd20},
        '{32'h001, 32'h040, 32'h3F0, 32'd4},
        '{32'h111, 32'h020, 32'h040, 32'd0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_en = 1'b0, reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        mem_req, mem_we, mem_gnt, mem_rvalid, irq;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    logic [31:0] mem     [MEM_WORDS];
    logic [31:0] exp_mem [MEM_WORDS];
    logic [31:0] rd_log  [64];
    int wr_total = 0, rd_total = 0, hs_err = 0;
    int errors = 0, checks = 0;
    logic [7:0]  lfsr;
    logic        prev_req, prev_gnt, prev_we;
    logic [31:0] prev_addr;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_channel #(.CHAN_ID(CHAN_ID)) u_dut (
        .clk(clk), .rst(rst), .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .irq(irq)
    );

    // behavioural memory with pseudo-random grant stalls and a handshake monitor
    always @(posedge clk) begin
        if (rst) begin
            mem_gnt    <= 1'b0;
            mem_rvalid <= 1'b0;
            mem_rdata  <= '0;
            lfsr       <= 8'hA5;
            prev_req   <= 1'b0;
            prev_gnt   <= 1'b0;
            prev_we    <= 1'b0;
            prev_addr  <= '0;
        end else begin
            lfsr       <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            mem_rvalid <= 1'b0;
            if (prev_req && !prev_gnt &&
                (!mem_req || mem_addr != prev_addr || mem_we != prev_we))
                hs_err <= hs_err + 1;
            prev_req  <= mem_req;
            prev_gnt  <= mem_gnt;
            prev_we   <= mem_we;
            prev_addr <= mem_addr;
            if (mem_req && mem_gnt) begin
                mem_gnt <= 1'b0;
                if (mem_we) begin
                    mem[mem_addr[9:2]] <= mem_wdata;
                    wr_total <= wr_total + 1;
                end else begin
                    mem_rdata  <= mem[mem_addr[9:2]];
                    mem_rvalid <= 1'b1;
                    rd_log[rd_total[5:0]] <= mem_addr;
                    rd_total <= rd_total + 1;
                end
            end else begin
                mem_gnt <= mem_req && lfsr[0];
            end
        end
    end

    task automatic check(input logic ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 4000; i++) begin
            reg_read(CTRL_A, v);
            if (!v[0]) return;
        end
    endtask

    task automatic fill_mem();
        for (int i = 0; i < MEM_WORDS; i++) mem[i] = 32'hDEAD_0000 | 32'(i);
    endtask

    task automatic run_vec(input logic [31:0] ti, input logic [31:0] src,
                           input logic [31:0] dst, input logic [31:0] len, input int id);
        int n, w0, r0, bad, first_bad;
        logic [31:0] v, sa, da;
        n = int'(len >> 2);
        fill_mem();
        for (int i = 0; i < n; i++) mem[(src >> 2) + 32'(i)] = (i == 0) ? MARK : ~MARK;
        mem[DESC_AT[9:2]]        = ti;
        mem[DESC_AT[9:2] + 8'd1] = src;
        mem[DESC_AT[9:2] + 8'd2] = dst;
        mem[DESC_AT[9:2] + 8'd3] = len;
        for (int i = 0; i < MEM_WORDS; i++) exp_mem[i] = mem[i];
        for (int i = 0; i < n; i++) begin
            sa = src + (ti[8] ? 32'(4 * i) : 32'd0);
            da = dst + (ti[4] ? 32'(4 * i) : 32'd0);
            exp_mem[da[9:2]] = mem[sa[9:2]];
        end
        reg_write(PTR_A, DESC_AT);
        w0 = wr_total; r0 = rd_total;
        reg_write(CTRL_A, 32'h1);
        wait_idle();
        repeat (2) @(negedge clk);
        // R2 run bit cleared after completion
        reg_read(CTRL_A, v);
        check(v[0] == 1'b0, $sformatf("R2 vec%0d run bit", id), v, 32'h0);
        // R4 descriptor fetch order
        bad = 0;
        for (int k = 0; k < 4; k++) if (rd_log[(r0 + k) % 64] != DESC_AT + 32'(4 * k)) bad++;
        check(bad == 0, $sformatf("R4 vec%0d fetch order", id), rd_log[r0 % 64], DESC_AT);
        // R4 word count
        check(wr_total - w0 == n, $sformatf("R4 vec%0d write count", id), 32'(wr_total - w0), 32'(n));
        // R5 R6 memory image
        bad = 0; first_bad = 0;
        for (int i = 0; i < MEM_WORDS; i++)
            if (mem[i] !== exp_mem[i]) begin
                if (bad == 0) first_bad = i;
                bad++;
            end
        check(bad == 0, $sformatf("R5/R6 vec%0d data word %0d", id, first_bad),
              mem[first_bad], exp_mem[first_bad]);
        // R7 completion flag
        check(v[2] == ti[0] && irq == ti[0], $sformatf("R7 vec%0d flag", id), {30'd0, irq, v[2]}, {30'd0, ti[0], ti[0]});
        reg_write(CTRL_A, 32'h4);
    endtask

    logic [31:0] rv;
    int w_snap, r_snap;
    bit done_flag = 0;

    initial begin
        for (int i = 0; i < 64; i++) rd_log[i] = '0;
        fill_mem();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        reg_read(CTRL_A, rv); check(rv == 0, "R1 control after reset", rv, 0);
        reg_read(PTR_A, rv);  check(rv == 0, "R1 pointer after reset", rv, 0);
        reg_read(SUM_A, rv);  check(rv == 0, "R1 summary after reset", rv, 0);
        check(!irq && !mem_req, "R1 irq/mem_req after reset", {30'd0, irq, mem_req}, 0);

        // R3 pointer read-back
        reg_write(PTR_A, 32'hA5C3_0F18);
        reg_read(PTR_A, rv); check(rv == 32'hA5C3_0F18, "R3 pointer read-back", rv, 32'hA5C3_0F18);

        // table of transfers
        for (int v = 0; v < NVEC; v++) run_vec(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], v);

        // R11 handshake monitor
        check(hs_err == 0, "R11 request held until grant", 32'(hs_err), 0);

        // R10 control writes during a running transfer
        fill_mem();
        mem[DESC_AT[9:2]] = 32'h111; mem[DESC_AT[9:2] + 8'd1] = 32'h020;
        mem[DESC_AT[9:2] + 8'd2] = 32'h040; mem[DESC_AT[9:2] + 8'd3] = 32'd32;
        reg_write(PTR_A, DESC_AT);
        w_snap = wr_total; r_snap = rd_total;
        reg_write(CTRL_A, 32'h1);
        reg_write(CTRL_A, 32'h1);
        reg_write(CTRL_A, 32'h0);
        reg_read(CTRL_A, rv);
        check(rv[0] == 1'b1, "R10 run bit kept during writes", rv, 32'h1);
        wait_idle();
        repeat (2) @(negedge clk);
        check(wr_total - w_snap == 8 && rd_total - r_snap == 12, "R10 single pass word count",
              32'(wr_total - w_snap), 32'd8);

        // R9 summary shows flag at CHAN_ID
        reg_read(SUM_A, rv);
        check(rv == (32'h1 << CHAN_ID), "R9 summary bit", rv, 32'h1 << CHAN_ID);

        // R8 writing zero to bit 2 keeps the flag, one clears it
        reg_write(CTRL_A, 32'h0);
        reg_read(CTRL_A, rv);
        check(rv[2] == 1'b1 && irq, "R8 flag kept on zero write", rv, 32'h4);
        reg_write(CTRL_A, 32'h4);
        reg_read(CTRL_A, rv);
        check(rv[2] == 1'b0 && !irq, "R8 flag cleared on one write", rv, 32'h0);

        // R9 another channel's window has no effect here
        w_snap = wr_total; r_snap = rd_total;
        reg_write({4'(CHAN_ID + 1), 8'h04}, 32'h0000_0200);
        reg_write({4'(CHAN_ID + 1), 8'h00}, 32'h1);
        repeat (20) @(negedge clk);
        reg_read(CTRL_A, rv);
        check(rv == 0 && rd_total == r_snap && wr_total == w_snap, "R9 foreign window ignored",
              rv, 32'h0);
        reg_read(PTR_A, rv);
        check(rv == DESC_AT, "R9 pointer untouched by foreign write", rv, DESC_AT);

        done_flag = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule